// File: doc/BRIEF.md
# Strobe-Decoded EDO Page-Mode DRAM Model

This block is a synthesizable stand-in for a 16-bit, two-byte-lane EDO DRAM. It is intended as a target for verifying memory controllers. On every clock it samples the active-low row strobe, the two lane column strobes, write enable, output enable and the multiplexed address. It works out the kind of each cycle from the order in which those strobes move, and then acts on a small internal array. The row and column address widths share one parameter, so the array has 2^(2*ADDR_W) words. The default of 3 gives 64 words.

It recognises the following cycles:
- reads, early writes and read-modify-writes;
- several column accesses under one open row (page mode);
- RAS-only refresh;
- CAS-before-RAS refresh, which takes its row from an internal counter;
- hidden refresh.

Read data is held on the outputs after the column strobe rises, as extended-data-out parts do. Every recognised cycle is reported on a one-cycle event output that carries a kind code, a page flag and the row. The refresh counter is visible on a debug port, so a bench can follow refresh coverage.

All pins are sampled synchronously. An edge is the difference between the value at this rising clock edge and the value at the previous one. Every effect becomes visible just after the clock edge at which the causing edge is sampled. The pins carry strobe-level timing and not a data stream, so there is no valid/ready handshake and the controller cannot be held off. The data bus is split into `dq_in`, `dq_out` and a per-lane drive enable `dq_oe`, which a board-level wrapper can combine into a tri-state bus.

Top module: `edo_dram_model`

## Requirements
- R1: While `rst_n` is low and right after its release, `dq_oe` is 0, `dq_out` is 0, `evt_valid` is 0 and `ref_row` is 0.
- R2: When RAS is first seen low while both CAS pins are high, `addr` is taken as the row. A later CAS fall with WE high takes `addr` as the column and reads the word at {row, column}. This raises `evt_valid` with `evt_kind`=1 (read) and `evt_row` equal to the row.
- R3: If WE is low at the sample where a CAS fall is seen, `dq_in` is written into the lanes whose CAS is low: lane 1 is bits 15:8 and follows `ucas_n`; lane 0 is bits 7:0 and follows `lcas_n`. The other lane of that word is unchanged. `dq_oe` drops to 0, and the event kind is 2.
- R4: Read data is driven only on the lanes whose CAS was low at the read's CAS fall. It is driven only when OE was low at the previous sample, so `dq_oe` lags OE by one clock.
- R5: Read data stays driven after CAS rises while RAS is low. A later CAS fall replaces it. It is withdrawn at the first sample that sees RAS and both CAS pins high.
- R6: In a read-modify-write, a read is followed, with some CAS still low, by a WE fall. At that WE fall, `dq_in` is written to the read's cell on the lanes whose CAS is low at that moment, and the event kind is 3.
- R7: If RAS rises after a row open with no CAS fall during that low period, the cycle is a RAS-only refresh: the event kind is 4, `evt_row` is the latched row, and `ref_row` does not change.
- R8: If any CAS is low at the sample where RAS is first seen low, the cycle is a CAS-before-RAS refresh. The event kind is 5, `evt_row` equals `ref_row` before the event, and `ref_row` then advances by one. `addr` is ignored and the array is not modified.
- R9: A CAS-before-RAS refresh that starts while read data is still held is a hidden refresh. This happens when CAS stays low across RAS high and then low. The event kind is 6, the counter advances as in R8, and the held data stays driven.
- R10: `ref_row` wraps from 2^ADDR_W-1 to 0.
- R11: `evt_page` is 1 on a read or early-write event that is not the first CAS access since the row was opened, and 0 on every other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Column strobe for lane 1 (bits 15:8), active low |
| lcas_n | input | 1 | Column strobe for lane 0 (bits 7:0), active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data, zero on lanes not driven |
| dq_oe | output | 2 | Per-lane drive enable (bit 1 = upper lane) |
| evt_valid | output | 1 | One-cycle pulse: a cycle was classified |
| evt_kind | output | 3 | 1 read, 2 early write, 3 read-modify-write, 4 RAS-only, 5 CAS-before-RAS, 6 hidden refresh |
| evt_page | output | 1 | Access is a follow-on page access |
| evt_row | output | ADDR_W | Row that the event acted on |
| ref_row | output | ADDR_W | Internal refresh row counter |

## Verification
A wrong phase or a wrong row latch shows up at the ports in the very next cycle: the event kind or `evt_row` differs from the reference model on the same clock as the strobe edge. Corruption of the array stays hidden until that cell is read back, so every write is followed by a read of the same cell, and of its neighbouring lane. A stale or lost data-valid flag shows as `dq_oe` staying high or dropping one clock after CAS rises or RAS closes. The refresh counter is compared on every clock, so a missed or doubled advance is caught at the refresh event itself.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_READ   = 3'd1,
    EV_EWRITE = 3'd2,
    EV_RMW    = 3'd3,
    EV_RONLY  = 3'd4,
    EV_CBR    = 3'd5,
    EV_HIDDEN = 3'd6
  } evt_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ROW  = 2'd1,
    PH_CBR  = 2'd2
  } phase_e;
endpackage

// File: rtl/edo_pin_sampler.sv
module edo_pin_sampler #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_n,
  output logic [N-1:0] pins_q
);
  // inactive (high) value after reset so no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '1;
    else        pins_q <= pins_n;
  end
endmodule

// File: rtl/edo_row_counter.sv
module edo_row_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + W'(1);
  end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int AW   = 6,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [1:0]      wr_lanes,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DQ_W-1:0] wr_data,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DQ_W-1:0] rd_data
);
  localparam int LANE_W = DQ_W / 2;
  localparam int WORDS  = 1 << AW;

  for (genvar l = 0; l < 2; l++) begin : gen_lane
    logic [LANE_W-1:0] cells [WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[l]) cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      if (rd_en) rd_data[l*LANE_W +: LANE_W] <= cells[rd_addr];
    end
  end
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
  import edo_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              ucas_n,
  input  logic              lcas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic [1:0]        dq_oe,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic              evt_page,
  output logic [ADDR_W-1:0] evt_row,
  output logic [ADDR_W-1:0] ref_row
);
  localparam int LANE_W  = DQ_W / 2;
  localparam int CELL_AW = 2 * ADDR_W;

  // previous samples of the strobes
  logic [4:0] pins_q;
  logic ras_q, ucas_q, lcas_q, we_q, oe_q;

  edo_pin_sampler #(.N(5)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_n ({oe_n, we_n, lcas_n, ucas_n, ras_n}),
    .pins_q (pins_q)
  );
  assign {oe_q, we_q, lcas_q, ucas_q, ras_q} = pins_q;

  // edge decode
  logic       ras_fall, ras_rise, cas_fall, we_fall, strobes_idle;
  logic [1:0] cas_low;
  assign ras_fall     = ras_q & ~ras_n;
  assign ras_rise     = ~ras_q & ras_n;
  assign cas_fall     = (ucas_q & ~ucas_n) | (lcas_q & ~lcas_n);
  assign we_fall      = we_q & ~we_n;
  assign cas_low      = {~ucas_n, ~lcas_n};
  assign strobes_idle = ras_n & ucas_n & lcas_n;

  // cycle state
  phase_e             phase;
  logic [ADDR_W-1:0]  row_r, col_r;
  logic               cas_seen, rmw_armed, data_valid;
  logic [1:0]         lane_mask;
  evt_kind_e          kind_r;
  logic [DQ_W-1:0]    rd_data;

  // cycle classification
  logic do_cbr, do_open, do_access, do_rd, do_wr, do_rmw, do_ras_only;
  assign do_cbr      = ras_fall & (|cas_low);
  assign do_open     = ras_fall & ~(|cas_low);
  assign do_access   = (phase == PH_ROW) & ~ras_n & cas_fall;
  assign do_rd       = do_access & we_n;
  assign do_wr       = do_access & ~we_n;
  assign do_rmw      = (phase == PH_ROW) & ~ras_n & rmw_armed & we_fall
                       & (|cas_low) & ~cas_fall;
  assign do_ras_only = ras_rise & (phase == PH_ROW) & ~cas_seen;

  edo_row_counter #(.W(ADDR_W)) u_refcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (do_cbr),
    .count (ref_row)
  );

  edo_cell_array #(.AW(CELL_AW), .DQ_W(DQ_W)) u_array (
    .clk      (clk),
    .wr_en    (do_wr | do_rmw),
    .wr_lanes (cas_low),
    .wr_addr  (do_rmw ? {row_r, col_r} : {row_r, addr}),
    .wr_data  (dq_in),
    .rd_en    (do_rd),
    .rd_addr  ({row_r, addr}),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      row_r      <= '0;
      col_r      <= '0;
      cas_seen   <= 1'b0;
      rmw_armed  <= 1'b0;
      data_valid <= 1'b0;
      lane_mask  <= '0;
      evt_valid  <= 1'b0;
      kind_r     <= EV_NONE;
      evt_page   <= 1'b0;
      evt_row    <= '0;
    end else begin
      evt_valid <= 1'b0;
      evt_page  <= 1'b0;

      // row strobe edges
      if (do_cbr) begin
        phase     <= PH_CBR;
        evt_valid <= 1'b1;
        kind_r    <= data_valid ? EV_HIDDEN : EV_CBR;
        evt_row   <= ref_row;
      end else if (do_open) begin
        phase    <= PH_ROW;
        row_r    <= addr;
        cas_seen <= 1'b0;
      end else if (ras_rise) begin
        phase <= PH_IDLE;
        if (do_ras_only) begin
          evt_valid <= 1'b1;
          kind_r    <= EV_RONLY;
          evt_row   <= row_r;
        end
      end

      // column access inside an open row
      if (do_access) begin
        col_r     <= addr;
        cas_seen  <= 1'b1;
        evt_valid <= 1'b1;
        evt_page  <= cas_seen;
        evt_row   <= row_r;
        kind_r    <= we_n ? EV_READ : EV_EWRITE;
      end

      if (do_rmw) begin
        evt_valid <= 1'b1;
        kind_r    <= EV_RMW;
        evt_row   <= row_r;
      end

      if (do_rd)                                          rmw_armed <= 1'b1;
      else if (do_rmw || ras_rise || (ucas_n && lcas_n))  rmw_armed <= 1'b0;

      // extended data out: hold until replaced or fully idle
      if (do_rd) begin
        data_valid <= 1'b1;
        lane_mask  <= cas_low;
      end else if (do_wr || strobes_idle) begin
        data_valid <= 1'b0;
      end
    end
  end

  assign evt_kind = kind_r;
  assign dq_oe    = lane_mask & {2{data_valid & ~oe_q}};
  assign dq_out   = rd_data & {{LANE_W{dq_oe[1]}}, {LANE_W{dq_oe[0]}}};
endmodule

// File: rtl/edo_dram_model_chk.sv
module edo_dram_model_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_n,
  input logic [1:0]        dq_oe,
  input logic              evt_valid,
  input logic [2:0]        evt_kind,
  input logic [ADDR_W-1:0] evt_row,
  input logic [ADDR_W-1:0] ref_row
);
  logic is_cbr;
  assign is_cbr = evt_valid && (evt_kind == 3'd5 || evt_kind == 3'd6);

  a_r4_oe_gates_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n) |-> dq_oe == 2'b00);

  a_r3_write_keeps_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd2) |-> dq_oe == 2'b00);

  a_r8_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    is_cbr |-> (ref_row == $past(ref_row) + ADDR_W'(1)) && (evt_row == $past(ref_row)));

  a_r10_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cbr |-> $stable(ref_row));

  a_r7_ras_only_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 3'd4) |-> $stable(ref_row));

  a_r1_no_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_kind != 3'd0);
endmodule

bind edo_dram_model edo_dram_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_n      (oe_n),
  .dq_oe     (dq_oe),
  .evt_valid (evt_valid),
  .evt_kind  (evt_kind),
  .evt_row   (evt_row),
  .ref_row   (ref_row)
);

// File: tb/edo_dram_model_test.sv
module edo_dram_model_test;
  localparam int AW   = 3;
  localparam int DW   = 16;
  localparam int ROWS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic [1:0]    dq_oe;
  logic          evt_valid, evt_page;
  logic [2:0]    evt_kind;
  logic [AW-1:0] evt_row, ref_row;

  always #2 clk = ~clk;  // 250 MHz

  edo_dram_model #(.ADDR_W(AW), .DQ_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_page(evt_page), .evt_row(evt_row), .ref_row(ref_row)
  );

  // behavioural reference state
  logic [15:0] m_mem [64];
  bit   m_rq, m_uq, m_lq, m_wq, m_oq;
  int   m_phase, m_row, m_col, m_ref;
  bit   m_seen, m_arm, m_valid;
  bit   [1:0] m_mask;
  logic [15:0] m_rd;
  bit   e_valid, e_page;
  int   e_kind, e_row;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [1:0] eoe;
    logic [15:0] eout;
    eoe  = m_mask & {2{m_valid & ~m_oq}};
    eout = m_rd & {{8{eoe[1]}}, {8{eoe[0]}}};
    chk("dq_oe", int'(dq_oe), int'(eoe));
    chk("dq_out", int'(dq_out), int'(eout));
    chk("evt_valid", int'(evt_valid), int'(e_valid));
    if (e_valid) begin
      chk("evt_kind", int'(evt_kind), e_kind);
      chk("evt_page", int'(evt_page), int'(e_page));
      chk("evt_row", int'(evt_row), e_row);
    end
    chk("ref_row", int'(ref_row), m_ref);
  endtask

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, bit [1:0] ln);
    logic [15:0] r;
    r = old;
    if (ln[1]) r[15:8] = nw[15:8];
    if (ln[0]) r[7:0]  = nw[7:0];
    return r;
  endfunction

  // state expected after the coming rising edge
  task automatic model_step();
    bit rf, rr, cf, wf, allh, old_seen, old_arm, old_valid;
    bit [1:0] cl;
    int old_phase;
    e_valid = 0; e_page = 0;
    if (!rst_n) begin
      m_rq = 1; m_uq = 1; m_lq = 1; m_wq = 1; m_oq = 1;
      m_phase = 0; m_row = 0; m_col = 0; m_ref = 0;
      m_seen = 0; m_arm = 0; m_valid = 0; m_mask = 0;
      return;
    end
    rf = m_rq && !ras_n;  rr = !m_rq && ras_n;
    cf = (m_uq && !ucas_n) || (m_lq && !lcas_n);
    wf = m_wq && !we_n;
    cl = {!ucas_n, !lcas_n};
    allh = ras_n && ucas_n && lcas_n;
    old_phase = m_phase; old_seen = m_seen; old_arm = m_arm; old_valid = m_valid;

    if (rf && cl != 0) begin
      e_valid = 1; e_kind = old_valid ? 6 : 5; e_row = m_ref;
      m_ref = (m_ref + 1) % ROWS; m_phase = 2;
    end else if (rf) begin
      m_row = int'(addr); m_phase = 1; m_seen = 0;
    end else if (rr) begin
      m_phase = 0;
      if (old_phase == 1 && !old_seen) begin e_valid = 1; e_kind = 4; e_row = m_row; end
    end

    if (old_phase == 1 && !ras_n && cf) begin
      m_col = int'(addr); m_seen = 1;
      e_valid = 1; e_page = old_seen; e_row = m_row;
      if (!we_n) begin
        e_kind = 2;
        m_mem[m_row*ROWS + m_col] = merge(m_mem[m_row*ROWS + m_col], dq_in, cl);
        m_valid = 0;
      end else begin
        e_kind = 1;
        m_rd = m_mem[m_row*ROWS + m_col];
        m_valid = 1; m_mask = cl; m_arm = 1;
      end
    end else if (old_phase == 1 && !ras_n && old_arm && wf && cl != 0) begin
      e_valid = 1; e_kind = 3; e_row = m_row;
      m_mem[m_row*ROWS + m_col] = merge(m_mem[m_row*ROWS + m_col], dq_in, cl);
      m_arm = 0;
    end else begin
      if (rr || (ucas_n && lcas_n)) m_arm = 0;
      if (allh) m_valid = 0;
    end

    m_rq = ras_n; m_uq = ucas_n; m_lq = lcas_n; m_wq = we_n; m_oq = oe_n;
  endtask

  task automatic cyc(bit r, bit u, bit l, bit w, bit o, int a, logic [15:0] d);
    @(negedge clk);
    compare_all();
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o;
    addr = AW'(a); dq_in = d;
    model_step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 1, 0, 16'h0);
  endtask

  task automatic early_write(int row, int col, bit [1:0] ln, logic [15:0] d);
    cyc(0, 1, 1, 1, 1, row, 16'h0);
    cyc(0, !ln[1], !ln[0], 0, 1, col, d);
    cyc(0, !ln[1], !ln[0], 0, 1, col, d);
    cyc(0, 1, 1, 1, 1, 0, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
  endtask

  task automatic read_cell(int row, int col, bit [1:0] ln);
    cyc(0, 1, 1, 1, 0, row, 16'h0);
    cyc(0, !ln[1], !ln[0], 1, 0, col, 16'h0);
    cyc(0, !ln[1], !ln[0], 1, 0, col, 16'h0);
    cyc(0, 1, 1, 1, 0, 0, 16'h0);      // EDO hold
    cyc(0, 1, 1, 1, 0, 0, 16'h0);
    cyc(1, 1, 1, 1, 0, 0, 16'h0);      // all idle: off
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
  endtask

  initial begin
    model_step();
    cur_req = "R1";
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    model_step();
    idle(2);

    cur_req = "R3";
    early_write(2, 5, 2'b11, 16'hA5C3);
    early_write(2, 6, 2'b10, 16'h1234);
    early_write(2, 6, 2'b01, 16'hFF56);
    early_write(4, 1, 2'b11, 16'h0F0F);
    early_write(4, 2, 2'b11, 16'h7E81);

    cur_req = "R2";
    read_cell(2, 5, 2'b11);
    read_cell(2, 6, 2'b11);

    cur_req = "R4";
    read_cell(2, 6, 2'b01);
    read_cell(4, 1, 2'b10);
    cyc(0, 1, 1, 1, 1, 4, 16'h0);      // OE high during read
    cyc(0, 0, 0, 1, 1, 2, 16'h0);
    cyc(0, 0, 0, 1, 0, 2, 16'h0);      // OE low: drive one clock later
    cyc(0, 0, 0, 1, 1, 2, 16'h0);      // OE high again
    cyc(0, 1, 1, 1, 1, 0, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);

    cur_req = "R5";
    cyc(0, 1, 1, 1, 0, 2, 16'h0);
    cyc(0, 0, 0, 1, 0, 5, 16'h0);
    cyc(0, 1, 1, 1, 0, 0, 16'h0);
    cyc(0, 1, 1, 1, 0, 0, 16'h0);
    cur_req = "R11";
    cyc(0, 0, 0, 1, 0, 6, 16'h0);      // page access replaces data
    cyc(0, 1, 1, 1, 0, 0, 16'h0);
    cyc(0, 0, 1, 0, 0, 7, 16'hBEEF);   // page early write, upper lane
    cyc(0, 1, 1, 1, 0, 0, 16'h0);
    cyc(1, 1, 1, 1, 0, 0, 16'h0);
    cur_req = "R5";
    read_cell(2, 7, 2'b10);

    cur_req = "R6";
    cyc(0, 1, 1, 1, 0, 4, 16'h0);
    cyc(0, 0, 0, 1, 0, 2, 16'h0);
    cyc(0, 0, 0, 1, 1, 2, 16'h0);
    cyc(0, 0, 0, 0, 1, 2, 16'hC0DE);   // WE fall: write back
    cyc(0, 0, 0, 0, 1, 2, 16'hC0DE);
    cyc(0, 1, 1, 1, 1, 0, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
    cyc(0, 1, 1, 1, 1, 4, 16'h0);      // lower-lane RMW
    cyc(0, 1, 0, 1, 0, 1, 16'h0);
    cyc(0, 1, 0, 0, 1, 1, 16'h9999);
    cyc(0, 1, 1, 1, 1, 0, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
    read_cell(4, 2, 2'b11);
    read_cell(4, 1, 2'b11);

    cur_req = "R7";
    cyc(0, 1, 1, 1, 1, 3, 16'h0);
    cyc(0, 1, 1, 1, 1, 6, 16'h0);
    cyc(0, 1, 1, 1, 1, 6, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
    idle(1);

    cur_req = "R8";
    cyc(1, 0, 0, 0, 1, 5, 16'hDEAD);
    cyc(0, 0, 0, 0, 1, 5, 16'hDEAD);   // CAS before RAS, junk address/WE
    cyc(0, 1, 1, 0, 1, 2, 16'hDEAD);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
    cyc(1, 1, 0, 1, 1, 0, 16'h0);      // single CAS also counts
    cyc(0, 1, 0, 1, 1, 0, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);
    read_cell(2, 5, 2'b11);            // array untouched

    cur_req = "R9";
    cyc(0, 1, 1, 1, 0, 2, 16'h0);
    cyc(0, 0, 0, 1, 0, 6, 16'h0);
    cyc(1, 0, 0, 1, 0, 0, 16'h0);      // RAS up, CAS held
    cyc(1, 0, 0, 1, 0, 0, 16'h0);
    cyc(0, 0, 0, 1, 0, 3, 16'h0);      // hidden refresh
    cyc(0, 0, 0, 1, 0, 3, 16'h0);
    cyc(1, 0, 0, 1, 0, 0, 16'h0);
    cyc(1, 1, 1, 1, 0, 0, 16'h0);
    cyc(1, 1, 1, 1, 1, 0, 16'h0);

    cur_req = "R10";
    for (int k = 0; k < ROWS + 2; k++) begin
      cyc(1, 0, 0, 1, 1, k, 16'h0);
      cyc(0, 0, 0, 1, 1, k, 16'h0);
      cyc(1, 1, 1, 1, 1, 0, 16'h0);
    end
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule